// File: doc/BRIEF.md
# Eight-Operand Carry-Save Summing Tree

This block adds eight unsigned operands of a configurable width and returns their total as one 12-bit word. It contains no state and no clock. The result follows the operands through combinational logic only. The operands arrive as one packed array, and the total is zero-extended to the output width.

Inside, the operands first go through two levels of 4:2 compressor rows. Each 4:2 cell is a pair of chained full adders. The first level turns eight words into four. The second level turns those four into a single sum/carry pair. That makes four full-adder delays of carry-save reduction in total.

The lowest column of the pair needs no addition, because the carry word is always zero there. The next column is resolved by one half adder, whose carry becomes the carry-in of the final adder. As a result, the closing carry-propagate adder spans only the upper ten columns rather than all twelve.

Top module: `csa8_tree`

## Requirements
- R1: `total_o` equals the arithmetic sum of all eight unsigned operands, for any operand values.
- R2: With the default 8-bit operands, the largest total is 2040 (0x7F8). It fits in the 12-bit output with bit 11 equal to zero, and no total ever exceeds eight times the largest operand value.
- R3: When every operand is zero, `total_o` is zero.
- R4: The block is purely combinational. A change on the operands appears on `total_o` without any clock edge.
- R5: Operand k occupies bits [k*WORD_W +: WORD_W] of `operands_i`, for k from 0 to 7. When only one operand is nonzero, the total equals that operand, whichever slot it occupies.
- R6: Every 4:2 cell conserves value: a+b+c+d+cin = sum + 2*(carry + cout). Its side carry-out does not depend on its own carry-in. Long carry patterns across the columns (alternating bits, all-ones, lone top bits) still give exact totals.
- R7: Bits [1:0] of the total come from outside the carry-propagate adder. Bit 0 is taken directly, and bit 1 comes from a half adder whose outputs satisfy {carry,sum} = a+b.
- R8: The carry-propagate adder covers bits [11:2] only. The half adder's carry enters it as carry-in, so totals whose low columns generate a carry are exact.
- R9: The output width must be at least WORD_W+3 bits. A narrower setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operands_i | input | 8*WORD_W (64) | Eight unsigned operands, operand k in bits [k*WORD_W +: WORD_W] |
| total_o | output | OUT_W (12) | Unsigned sum of the eight operands, zero-extended |

## Verification
The embedded checks assume that all eight operands hold known two-state values and that the output width satisfies R9. Under these assumptions the exact total, and every intermediate carry-save pair, stays below 2^OUT_W, so modular arithmetic inside the tree never loses a bit. The stimulus keeps to this by driving every operand slot with a defined value from time zero. It uses the default widths throughout, so even the all-ones case (2040) is covered without overflow.

// File: rtl/csa8_pkg.sv
package csa8_pkg;
  // number of operands the tree reduces
  localparam int NUM_OPS  = 8;
  // low columns resolved outside the final carry-propagate adder
  localparam int LOW_COLS = 2;
  // operands consumed by one 4:2 compressor row
  localparam int ROW_IN   = 4;
  // rows in the first reduction level
  localparam int LVL1_ROWS = NUM_OPS / ROW_IN;
endpackage

// File: rtl/csa_fa.sv
module csa_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic ab_x;

  assign ab_x = a_i ^ b_i;
  assign s_o  = ab_x ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & ab_x);
endmodule

// File: rtl/csa_ha.sv
module csa_ha (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = a_i ^ b_i;
  assign c_o = a_i & b_i;

  // R7: the half adder keeps the dot count, only relocating weight
  always_comb begin
    p_ha_moves_dots_r7: assert ({c_o, s_o} == ({1'b0, a_i} + {1'b0, b_i}))
      else $error("half adder output mismatch");
  end
endmodule

// File: rtl/csa_comp42.sv
module csa_comp42 (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic d_i,
  input  logic ci_i,
  output logic sum_o,
  output logic carry_o,
  output logic co_o
);
  logic mid_s;

  // first full adder: its carry is the side carry, independent of ci_i
  csa_fa u_fa_lo (
    .a_i (a_i),
    .b_i (b_i),
    .c_i (c_i),
    .s_o (mid_s),
    .co_o(co_o)
  );

  // second full adder folds in the fourth input and the side carry-in
  csa_fa u_fa_hi (
    .a_i (mid_s),
    .b_i (d_i),
    .c_i (ci_i),
    .s_o (sum_o),
    .co_o(carry_o)
  );

  // R6: value conservation of the 5:3 cell
  always_comb begin
    p_cell_conserve_r6: assert (
      ({2'b0, a_i} + {2'b0, b_i} + {2'b0, c_i} + {2'b0, d_i} + {2'b0, ci_i}) ==
      ({2'b0, sum_o} + {1'b0, carry_o, 1'b0} + {1'b0, co_o, 1'b0}))
      else $error("4:2 cell does not conserve value");
  end
endmodule

// File: rtl/csa_row42.sv
module csa_row42 #(
  parameter int N = 12
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] carry_o
);
  localparam int EXT_W = N + 2;

  logic [N-1:0] side_co;
  logic [N-1:0] side_ci;
  logic [N:0]   carry_w;

  // lowest column sees no side carry; the chain is one cell long per column
  assign side_ci[0] = 1'b0;
  assign carry_w[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_col
      if (i > 0) begin : g_link
        assign side_ci[i] = side_co[i-1];
      end
      csa_comp42 u_cell (
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .c_i    (c_i[i]),
        .d_i    (d_i[i]),
        .ci_i   (side_ci[i]),
        .sum_o  (sum_o[i]),
        .carry_o(carry_w[i+1]),
        .co_o   (side_co[i])
      );
    end
  endgenerate

  // carry word is the cell carries moved up one column
  assign carry_o = carry_w[N-1:0];

  // R6: the whole row keeps the exact value, top carries included
  always_comb begin
    p_row_conserve_r6: assert (
      (EXT_W'(a_i) + EXT_W'(b_i) + EXT_W'(c_i) + EXT_W'(d_i)) ==
      (EXT_W'(sum_o) + EXT_W'(carry_w) + (EXT_W'(side_co[N-1]) << N)))
      else $error("4:2 row does not conserve value");
  end
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int N = 10
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] s_o
);
  assign s_o = a_i + b_i + N'(cin_i);
endmodule

// File: rtl/csa8_tree.sv
module csa8_tree
  import csa8_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int OUT_W  = 12
) (
  input  logic [NUM_OPS-1:0][WORD_W-1:0] operands_i,
  output logic [OUT_W-1:0]               total_o
);
  localparam int CPA_W = OUT_W - LOW_COLS;
  localparam logic [OUT_W-1:0] MAX_SUM = OUT_W'(NUM_OPS * ((1 << WORD_W) - 1));

  // R9: output must hold eight full-scale operands
  generate
    if (OUT_W < WORD_W + 3) begin : g_width_bad
      $error("OUT_W too small for eight operands");
    end
  endgenerate

  logic [NUM_OPS-1:0][OUT_W-1:0]   ext;
  logic [LVL1_ROWS-1:0][OUT_W-1:0] sa;
  logic [LVL1_ROWS-1:0][OUT_W-1:0] ca;
  logic [OUT_W-1:0]                sb;
  logic [OUT_W-1:0]                cb;
  logic                            lo_carry;

  genvar k, g;
  generate
    // zero-extend operands; constant upper columns are left to synthesis
    for (k = 0; k < NUM_OPS; k++) begin : g_ext
      assign ext[k] = OUT_W'(operands_i[k]);
    end

    // level one: eight words to four
    for (g = 0; g < LVL1_ROWS; g++) begin : g_lvl1
      csa_row42 #(.N(OUT_W)) u_row (
        .a_i    (ext[ROW_IN*g]),
        .b_i    (ext[ROW_IN*g+1]),
        .c_i    (ext[ROW_IN*g+2]),
        .d_i    (ext[ROW_IN*g+3]),
        .sum_o  (sa[g]),
        .carry_o(ca[g])
      );
    end
  endgenerate

  // level two: four words to one sum/carry pair
  csa_row42 #(.N(OUT_W)) u_row_lvl2 (
    .a_i    (sa[0]),
    .b_i    (ca[0]),
    .c_i    (sa[1]),
    .d_i    (ca[1]),
    .sum_o  (sb),
    .carry_o(cb)
  );

  // column 0 holds a single dot; column 1 is cleared by a half adder
  assign total_o[0] = sb[0];

  csa_ha u_ha_col1 (
    .a_i(sb[1]),
    .b_i(cb[1]),
    .s_o(total_o[1]),
    .c_o(lo_carry)
  );

  // narrowed final adder, half-adder carry enters as carry-in
  csa_cpa #(.N(CPA_W)) u_cpa (
    .a_i  (sb[OUT_W-1:LOW_COLS]),
    .b_i  (cb[OUT_W-1:LOW_COLS]),
    .cin_i(lo_carry),
    .s_o  (total_o[OUT_W-1:LOW_COLS])
  );

  // behavioural reference for the checks below
  logic [OUT_W-1:0] ref_sum;
  always_comb begin
    ref_sum = '0;
    for (int j = 0; j < NUM_OPS; j++) begin
      ref_sum = ref_sum + OUT_W'(operands_i[j]);
    end
  end

  always_comb begin
    // R1: the reduced pair still carries the exact total
    p_pair_exact_r1: assert ((sb + cb) == ref_sum)
      else $error("carry-save pair lost value");
    // R1: final total matches the reference
    p_sum_exact_r1: assert (total_o == ref_sum)
      else $error("total mismatch");
    // R2: never beyond the full-scale total
    p_no_overflow_r2: assert (total_o <= MAX_SUM)
      else $error("total exceeds full scale");
  end
endmodule

// File: tb/csa8_tree_test.sv
module csa8_tree_test;
  localparam int W  = 8;
  localparam int OW = 12;
  localparam int NO = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [NO-1:0][W-1:0] ops;
  logic [OW-1:0]        total;

  int n_checks = 0;
  int n_err    = 0;

  csa8_tree #(.WORD_W(W), .OUT_W(OW)) uut (
    .operands_i(ops),
    .total_o   (total)
  );

  function automatic int ref_total(logic [NO-1:0][W-1:0] v);
    int s = 0;
    for (int k = 0; k < NO; k++) s += int'(v[k]);
    return s;
  endfunction

  task automatic check(string req, int exp);
    n_checks++;
    if (int'(total) !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, total, exp);
    end
  endtask

  task automatic apply(logic [NO-1:0][W-1:0] v);
    @(posedge clk);
    ops = v;
    #5;
  endtask

  task automatic t_zero;
    apply('0);
    check("R3 all zero", 0);
  endtask

  task automatic t_full_scale;
    logic [NO-1:0][W-1:0] v;
    for (int k = 0; k < NO; k++) v[k] = 8'hFF;
    apply(v);
    check("R2 all ones", 2040);
    n_checks++;
    if (total[OW-1] !== 1'b0) begin
      n_err++;
      $display("FAIL R2 top bit: got %0b expected 0", total[OW-1]);
    end
  endtask

  task automatic t_single_slot;
    logic [NO-1:0][W-1:0] v;
    for (int k = 0; k < NO; k++) begin
      v = '0;
      v[k] = W'(k * 31 + 7);
      apply(v);
      check($sformatf("R5 slot %0d", k), k * 31 + 7);
    end
  endtask

  task automatic t_low_columns;
    logic [NO-1:0][W-1:0] v;
    for (int k = 0; k < NO; k++) v[k] = 8'd3;
    apply(v);
    check("R7 R8 all threes", 24);
    for (int k = 0; k < NO; k++) v[k] = (k % 2 == 0) ? 8'd1 : 8'd2;
    apply(v);
    check("R7 R8 ones and twos", 12);
    v = '0;
    v[0] = 8'd2;
    v[5] = 8'd2;
    apply(v);
    check("R7 R8 column one carry", 4);
  endtask

  task automatic t_carry_patterns;
    logic [NO-1:0][W-1:0] v;
    for (int k = 0; k < NO; k++) v[k] = (k % 2 == 0) ? 8'hAA : 8'h55;
    apply(v);
    check("R6 alternating bits", 4 * 170 + 4 * 85);
    for (int k = 0; k < NO; k++) v[k] = 8'h80;
    apply(v);
    check("R6 lone top bits", 1024);
    for (int k = 0; k < NO; k++) v[k] = (k < 4) ? 8'hFF : 8'h01;
    apply(v);
    check("R6 ones plus units", 4 * 255 + 4);
    for (int k = 0; k < NO; k++) v[k] = 8'h7F;
    apply(v);
    check("R6 all 0x7F", 8 * 127);
  endtask

  task automatic t_combinational;
    logic [NO-1:0][W-1:0] v;
    @(posedge clk);
    #3;
    v = '0;
    v[2] = 8'd100;
    v[6] = 8'd55;
    ops = v;
    #1;
    check("R4 no clock edge needed", 155);
    v[6] = 8'd200;
    ops = v;
    #1;
    check("R4 second change mid cycle", 300);
  endtask

  task automatic t_random;
    logic [NO-1:0][W-1:0] v;
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < NO; k++) v[k] = W'($urandom);
      apply(v);
      check("R1 random", ref_total(v));
    end
  endtask

  initial begin
    ops = '0;
    #1;
    t_zero();
    t_full_scale();
    t_single_slot();
    t_low_columns();
    t_carry_patterns();
    t_combinational();
    t_random();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule